// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block reads 16-bit words from a three-wire serial EEPROM. It drives the chip select, shift clock and serial data toward the memory, and it samples the memory's serial output. Every access is a read. Each half-period of the shift clock lasts `div_cfg` system clocks, and the value is captured when an access starts.

After reset the block configures itself. It reads word 0 with 8-bit addressing and compares the result with a signature word. If the two match, all later accesses use 8 address bits. Otherwise they use 6 address bits. The block then reads the three words that hold the 48-bit station address and presents that address with a valid flag. Only after this does it accept host reads.

A host read is a valid/ready request carrying a word address. Back-pressure works only on the request side: `req_valid` with `req_addr` must stay stable until a rising edge at which `req_ready` is high, and that edge accepts the request. The answer comes back as a single-cycle `rsp_valid` pulse with `rsp_data`. The response side cannot stall the block.

Top module: `mw_eeprom_reader`

## Requirements
- R1: While reset is asserted and in the first clock after its release, `ee_cs`, `ee_sk`, `ee_di`, `req_ready`, `rsp_valid` and `mac_valid` are all low. The self-configuration read drives `ee_cs` high starting in the second clock after reset release.
- R2: Every half-period of an access lasts `div_cfg` clocks, with a value of 0 treated as 1. The value is taken at the clock edge that starts the access.
- R3: An access begins with one half-period of `ee_cs` high and `ee_sk` low. Then come the bits 1,1,0 followed by the address bits, most significant first. Each bit is held on `ee_di` for one low half-period and then the following high half-period. The opcodes 101 and 111 are never sent.
- R4: After the last address bit comes one low half-period. Then 16 high/low half-period pairs follow. `ee_do` is sampled on the last clock of each high half-period, and the word is assembled most significant bit first. `ee_di` is low from the gap onward.
- R5: After the 16th low half-period, `ee_cs` and `ee_sk` are low for one half-period. `ee_sk` is never high while `ee_cs` is low.
- R6: The self-configuration read fetches word 0 with 8 address bits. `addr_wide` becomes 1 when that word equals 0x8129 and 0 otherwise. All later accesses use 8 or 6 address bits accordingly.
- R7: Words 7, 8 and 9 are then read back to back, with one idle clock after each access. `mac_addr[47:40]` is the low byte of word 7 and `[39:32]` its high byte, and words 8 and 9 follow in the same way. `mac_valid` rises one clock after the third access ends, and from then on `mac_valid` and `mac_addr` do not change.
- R8: `req_ready` is high only after `mac_valid` is set and no access is running. A request held while `req_ready` is low is taken at the first edge at which `req_ready` is high. In 6-bit mode only `req_addr[5:0]` is sent.
- R9: In the clock right after the deselect half-period of a host read, `rsp_valid` is high for exactly one clock, `rsp_data` holds the word and `req_ready` is high. `rsp_valid` is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | DIV_W | Half-period length in clocks (0 acts as 1) |
| req_valid | input | 1 | Host read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | One-cycle pulse: read word available |
| rsp_data | output | 16 | Word returned by a host read |
| addr_wide | output | 1 | 1 = 8-bit addressing, 0 = 6-bit |
| mac_addr | output | 16*MAC_WORDS | Station address, first byte in the top bits |
| mac_valid | output | 1 | Station address fetched |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory shift clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The hardest case to reach is the 6-bit outcome of width detection. The probe read then sends more address bits than the memory expects, so the memory starts returning data while the block is still sending address bits. The word that comes back is misaligned and must still not be taken as the signature. The bench reaches this case with a behavioural memory model whose address width can be changed. It resets the block once against a 6-bit memory and once against an 8-bit memory that holds the signature. Requests are also issued while the block is busy, and at half-period settings of 0 and 1, so that hold-off and the shortest timing are exercised at the same time.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {CT_BOOT, CT_RUN, CT_IDLE} ctl_e;
  typedef enum logic [1:0] {JB_PROBE, JB_MAC, JB_HOST} job_e;
  localparam int WORD_W = 16;
  localparam logic [2:0] OP_READ = 3'b110;
endpackage

// File: rtl/mw_halfper_div.sv
module mw_halfper_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             tick
);
  logic [DIV_W-1:0] len_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= DIV_W'(1);
      cnt_q <= '0;
    end else if (load) begin
      len_q <= (div_cfg == '0) ? DIV_W'(1) : div_cfg;
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SHORT_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tick,
  input  logic              ee_do,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] word
);
  localparam int CMD_W  = 3 + ADDR_W;
  localparam int NC_L   = 3 + ADDR_W;
  localparam int NC_S   = 3 + SHORT_AW;
  localparam int LAST_L = 2 * NC_L + 2 + 2 * WORD_W;
  localparam int HW     = $clog2(LAST_L + 1);

  logic              busy_q, done_q, wide_q;
  logic [HW-1:0]     h_q;
  logic [CMD_W-1:0]  cmd_q, cmd_load;
  logic [WORD_W-1:0] sh_q;
  logic [HW-1:0]     nc2, dat0_h, last_h, dk;
  logic              in_cmd, in_data;

  // short addressing: address left-aligned, padding never leaves the register
  generate
    if (ADDR_W > SHORT_AW) begin : g_pad
      assign cmd_load = wide_i ? {OP_READ, addr_i}
                               : {OP_READ, addr_i[SHORT_AW-1:0], {(ADDR_W-SHORT_AW){1'b0}}};
    end else begin : g_same
      assign cmd_load = {OP_READ, addr_i};
    end
  endgenerate

  assign nc2    = wide_q ? HW'(2 * NC_L) : HW'(2 * NC_S);
  assign dat0_h = nc2 + HW'(2);
  assign last_h = dat0_h + HW'(2 * WORD_W);
  assign dk     = h_q - dat0_h;

  always_comb begin
    ee_cs   = 1'b0;
    ee_sk   = 1'b0;
    ee_di   = 1'b0;
    in_cmd  = 1'b0;
    in_data = 1'b0;
    if (busy_q) begin
      if (h_q == '0) begin
        ee_cs = 1'b1;
      end else if (h_q <= nc2) begin
        ee_cs  = 1'b1;
        in_cmd = 1'b1;
        ee_sk  = ~h_q[0];
        ee_di  = cmd_q[CMD_W-1];
      end else if (h_q < last_h) begin
        ee_cs = 1'b1;
        if (h_q >= dat0_h) begin
          in_data = 1'b1;
          ee_sk   = ~dk[0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wide_q <= 1'b0;
      h_q    <= '0;
      cmd_q  <= '0;
      sh_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q <= 1'b1;
        h_q    <= '0;
        cmd_q  <= cmd_load;
        wide_q <= wide_i;
      end else if (busy_q && tick) begin
        if (h_q == last_h) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          h_q <= h_q + 1'b1;
        end
        if (in_cmd && ee_sk) cmd_q <= cmd_q << 1;
        if (in_data && ee_sk) sh_q <= {sh_q[WORD_W-2:0], ee_do};
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign word = sh_q;
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_pkg::*;
#(
  parameter int              DIV_W     = 8,
  parameter int              ADDR_W    = 8,
  parameter int              SHORT_AW  = 6,
  parameter logic [15:0]     WIDE_SIG  = 16'h8129,
  parameter int              MAC_BASE  = 7,
  parameter int              MAC_WORDS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIV_W-1:0]        div_cfg,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    rsp_valid,
  output logic [15:0]             rsp_data,
  output logic                    addr_wide,
  output logic [16*MAC_WORDS-1:0] mac_addr,
  output logic                    mac_valid,
  output logic                    ee_cs,
  output logic                    ee_sk,
  output logic                    ee_di,
  input  logic                    ee_do
);
  localparam int MAC_W = WORD_W * MAC_WORDS;
  localparam int MIW   = (MAC_WORDS > 1) ? $clog2(MAC_WORDS) : 1;
  localparam logic [MIW-1:0] MIDX_LAST = MIW'(MAC_WORDS - 1);

  ctl_e              ctl_q;
  job_e              job_q;
  logic [MIW-1:0]    midx_q;
  logic              wide_q, macv_q;
  logic [MAC_W-1:0]  mac_q;

  logic              start, st_wide, tick, busy, done, sig_hit;
  logic [ADDR_W-1:0] st_addr;
  logic [WORD_W-1:0] word;

  mw_halfper_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(start && !busy), .run(busy),
    .div_cfg(div_cfg), .tick(tick)
  );

  mw_frame #(.ADDR_W(ADDR_W), .SHORT_AW(SHORT_AW)) u_frame (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_i(st_wide), .addr_i(st_addr),
    .tick(tick), .ee_do(ee_do), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .busy(busy), .done(done), .word(word)
  );

  assign sig_hit = (word == WIDE_SIG);

  always_comb begin
    start   = 1'b0;
    st_addr = '0;
    st_wide = wide_q;
    unique case (ctl_q)
      CT_BOOT: begin
        start   = 1'b1;
        st_wide = 1'b1;
      end
      CT_RUN: begin
        if (done && job_q == JB_PROBE) begin
          start   = 1'b1;
          st_addr = ADDR_W'(MAC_BASE);
          st_wide = sig_hit;
        end else if (done && job_q == JB_MAC && midx_q != MIDX_LAST) begin
          start   = 1'b1;
          st_addr = ADDR_W'(MAC_BASE) + ADDR_W'(midx_q) + ADDR_W'(1);
        end
      end
      default: begin
        if (req_valid && !busy) begin
          start   = 1'b1;
          st_addr = req_addr;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CT_BOOT;
      job_q  <= JB_PROBE;
      midx_q <= '0;
      wide_q <= 1'b0;
      macv_q <= 1'b0;
      mac_q  <= '0;
    end else begin
      unique case (ctl_q)
        CT_BOOT: begin
          ctl_q <= CT_RUN;
          job_q <= JB_PROBE;
        end
        CT_RUN: begin
          if (done && job_q == JB_PROBE) begin
            wide_q <= sig_hit;
            job_q  <= JB_MAC;
            midx_q <= '0;
          end else if (done && job_q == JB_MAC) begin
            mac_q <= {mac_q[MAC_W-WORD_W-1:0], word[7:0], word[15:8]};
            if (midx_q == MIDX_LAST) begin
              ctl_q  <= CT_IDLE;
              macv_q <= 1'b1;
            end else begin
              midx_q <= midx_q + 1'b1;
            end
          end
        end
        default: begin
          if (start) job_q <= JB_HOST;
        end
      endcase
    end
  end

  assign req_ready = (ctl_q == CT_IDLE) && !busy;
  assign rsp_valid = done && (job_q == JB_HOST);
  assign rsp_data  = word;
  assign addr_wide = wide_q;
  assign mac_addr  = mac_q;
  assign mac_valid = macv_q;
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk #(
  parameter int MAC_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             mac_valid,
  input logic [MAC_W-1:0] mac_addr,
  input logic             ee_cs,
  input logic             ee_sk,
  input logic             ee_di
);
  a_r5_sk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk);

  a_r3_di_stable_sk_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_cs && ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  a_r9_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  a_r8_ready_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ee_cs);

  a_r8_ready_after_mac: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mac_valid);

  a_r7_mac_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mac_valid |=> (mac_valid && $stable(mac_addr)));
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk #(.MAC_W(MAC_W)) u_chk (.*);

// File: tb/tb_mw_eeprom_reader.sv
module tb_mw_eeprom_reader;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div_cfg = 8'd3;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        addr_wide;
  logic [47:0] mac_addr;
  logic        mac_valid;
  logic        ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;

  mw_eeprom_reader dut (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .addr_wide(addr_wide), .mac_addr(mac_addr),
    .mac_valid(mac_valid), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
    .ee_do(ee_do)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural serial memory
  logic [15:0] mem [0:255];
  int          dev_aw = 6;
  int          dn = 0;
  logic [7:0]  da = '0;
  logic [2:0]  dop = '0;

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) begin
      dn = 0; da = '0; dop = '0; ee_do = 1'b0;
    end else begin
      int k;
      dn++;
      if (dn <= 3) dop = {dop[1:0], ee_di};
      else if (dn <= 3 + dev_aw) da = {da[6:0], ee_di};
      else begin
        k = dn - 4 - dev_aw;
        ee_do = (k < 16) ? mem[da & 8'((1 << dev_aw) - 1)][15-k] : 1'b0;
      end
      if (dn == 3) chk(dop == 3'b110, "R3 opcode", 48'(dop), 48'(3'b110));
    end
  end

  // reference model: per-clock expected pins {cs,sk,di,host_last,init_end}
  logic [4:0]  expq[$];
  logic [15:0] expdq[$];
  bit          mon_on = 0, rsp_due = 0, mac_flag = 0, exp_wide = 0, acc = 0;
  logic [15:0] exp_d = '0;
  logic [47:0] exp_mac = '0;

  task automatic push_hp(input bit c, input bit s, input bit d, input int n);
    repeat (n) expq.push_back({c, s, d, 2'b00});
  endtask

  task automatic push_access(input logic [7:0] addr, input bit wide, input int dv);
    int n = (dv == 0) ? 1 : dv;
    int aw = wide ? 8 : 6;
    logic [2:0] op = 3'b110;
    push_hp(1, 0, 0, n);
    for (int i = 2; i >= 0; i--) begin push_hp(1, 0, op[i], n); push_hp(1, 1, op[i], n); end
    for (int i = aw - 1; i >= 0; i--) begin push_hp(1, 0, addr[i], n); push_hp(1, 1, addr[i], n); end
    push_hp(1, 0, 0, n);
    for (int i = 0; i < 16; i++) begin push_hp(1, 1, 0, n); push_hp(1, 0, 0, n); end
    push_hp(0, 0, 0, n);
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      logic [4:0] e;
      bit rdy_exp;
      rdy_exp = (expq.size() == 0);
      chk(req_ready == rdy_exp, "R8 req_ready", 48'(req_ready), 48'(rdy_exp));
      chk(rsp_valid == rsp_due, "R9 rsp_valid", 48'(rsp_valid), 48'(rsp_due));
      if (rsp_due) chk(rsp_data == exp_d, "R9 rsp_data", 48'(rsp_data), 48'(exp_d));
      chk(mac_valid == mac_flag, "R7 mac_valid", 48'(mac_valid), 48'(mac_flag));
      if (mac_flag) begin
        chk(mac_addr == exp_mac, "R7 mac_addr", mac_addr, exp_mac);
        chk(addr_wide == exp_wide, "R6 addr_wide", 48'(addr_wide), 48'(exp_wide));
      end
      e = rdy_exp ? 5'b0 : expq.pop_front();
      // R2 R3 R4 R5: pin waveform including half-period length
      chk({ee_cs, ee_sk, ee_di} == e[4:2], "R2 R3 R4 R5 pins", 48'({ee_cs, ee_sk, ee_di}), 48'(e[4:2]));
      rsp_due = e[1];
      if (e[1]) exp_d = expdq.pop_front();
      if (e[0]) mac_flag = 1;
      if (rdy_exp && req_valid) begin
        push_access(req_addr, exp_wide, int'(div_cfg));
        expq[expq.size()-1][1] = 1'b1;
        expdq.push_back(mem[req_addr & (exp_wide ? 8'hFF : 8'h3F)]);
        acc = 1;
      end
    end
  end

  task automatic do_reset(input bit wide);
    @(posedge clk); #1;
    mon_on = 0; rst_n = 0;
    expq.delete(); expdq.delete();
    rsp_due = 0; mac_flag = 0; exp_wide = wide;
    exp_mac = {mem[7][7:0], mem[7][15:8], mem[8][7:0], mem[8][15:8], mem[9][7:0], mem[9][15:8]};
    repeat (3) begin
      @(negedge clk);
      chk({ee_cs, ee_sk, ee_di, req_ready, rsp_valid, mac_valid} == 6'b0, "R1 reset outputs",
          48'({ee_cs, ee_sk, ee_di, req_ready, rsp_valid, mac_valid}), 48'(0));
    end
    @(posedge clk); #1;
    rst_n = 1;
    push_hp(0, 0, 0, 1);                       // R1: boot clock
    push_access(8'h00, 1'b1, int'(div_cfg));   // R6 probe, 8-bit
    for (int w = 7; w <= 9; w++) begin
      push_hp(0, 0, 0, 1);
      push_access(8'(w), wide, int'(div_cfg)); // R7 station address words
    end
    push_hp(0, 0, 0, 1);
    expq[expq.size()-1][0] = 1'b1;
    mon_on = 1;
  endtask

  task automatic host_rd(input logic [7:0] a);
    @(posedge clk); #1;
    acc = 0; req_valid = 1; req_addr = a;
    do @(posedge clk); while (!acc);
    #1 req_valid = 0; acc = 0;
  endtask

  task automatic wait_idle();
    do @(posedge clk); while (expq.size() != 0 || rsp_due);
    repeat (2) @(posedge clk);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    chk(1'b0, "watchdog R1", 48'(0), 48'(1));
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 16'h9E37) ^ 16'h5A5A);
    // Phase A: 6-bit memory, signature absent
    mem[0] = 16'h1234; mem[7] = 16'hA1B2; mem[8] = 16'hC3D4; mem[9] = 16'hE5F6;
    dev_aw = 6; div_cfg = 8'd3;
    do_reset(1'b0);
    wait_idle();
    chk(addr_wide == 1'b0, "R6 narrow detect", 48'(addr_wide), 48'(0));
    chk(mac_addr == 48'hB2A1_D4C3_F6E5, "R7 byte order", mac_addr, 48'hB2A1_D4C3_F6E5);
    host_rd(8'd5);
    host_rd(8'd63);          // R8: held while busy
    wait_idle();
    @(posedge clk); #1 div_cfg = 8'd1;
    host_rd(8'hC7);          // R8: upper bits dropped, reads word 7
    wait_idle();
    @(posedge clk); #1 div_cfg = 8'd0;  // R2: zero acts as one
    host_rd(8'd9);
    wait_idle();

    // Phase B: 8-bit memory holding the signature
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 16'h3B9D) ^ 16'hC0DE);
    mem[0] = 16'h8129; mem[7] = 16'h0102; mem[8] = 16'h0304; mem[9] = 16'h0506;
    dev_aw = 8; div_cfg = 8'd2;
    do_reset(1'b1);
    wait_idle();
    chk(addr_wide == 1'b1, "R6 wide detect", 48'(addr_wide), 48'(1));
    chk(mac_addr == 48'h0201_0403_0605, "R7 byte order wide", mac_addr, 48'h0201_0403_0605);
    host_rd(8'hA5);
    host_rd(8'hFF);
    wait_idle();
    @(posedge clk); #1 div_cfg = 8'd5;
    host_rd(8'h3C);
    wait_idle();
    report();
  end
endmodule